// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received serial frames into host memory buffers. Each serial port has its own ring of receive descriptors. When the first byte of a frame arrives, the block reads the descriptor at that port's current ring position and checks the ownership bit. It then streams the frame bytes into the buffer the descriptor points to, one byte per write on a plain memory write port. When the frame ends or the buffer is full, it writes back the status byte and the message count, which also returns the descriptor to the host. A completion event is raised when the descriptor asks for one.

Frames longer than one buffer continue into the following descriptors. Start-of-packet and end-of-packet flags mark the first and last descriptor of a frame. The byte source stands in for the deserializer and CRC logic. It presents bytes with a ready/valid handshake, and the framing and CRC error strobes are valid with the last byte. The host gives a descriptor back to the engine by setting its ownership bit. The engine reads the descriptor again every time it uses it.

Top module: `rxd_ring_writer`

## Requirements
- R1: After reset, rx_ready, buf_we, desc_rd_en, desc_wr_en and evt_valid are all low, and every port's ring position is 0.
- R2: A descriptor is 64 bits wide, packed as [15:0] low buffer address, [23:16] high address byte, [31:24] status, [47:32] buffer count, [63:48] message count. To fetch one, desc_rd_en is high for one cycle with desc_rd_addr = port*RING_DEPTH + position. desc_rd_data is valid in the cycle that follows.
- R3: Frame bytes are written only into a descriptor whose status bit 7 (ownership) was read as 1. The write-back clears bit 7.
- R4: The buffer size is 32768 minus bits 14:0 of the buffer count, so 0 means 32768. Byte k of a descriptor goes to address {high[3:0], low} + k.
- R5: If a buffer fills before the last byte, the descriptor is written back and the next one is fetched for the rest of the frame. Status bit 1 (start) is set on the first descriptor of a frame, bit 0 (end) on the last, and neither on those in between.
- R6: The written message count is the number of frame bytes stored up to and including that descriptor, modulo 2^15. On the end descriptor this equals the frame length.
- R7: rx_fram_err and rx_crc_err are sampled with the last byte and set status bit 5 and bit 3 of the end descriptor. Bit 6 is set exactly when any of bits 5, 4, 3 or 2 is set.
- R8: If the fetched descriptor is not owned, the rest of the frame is accepted and discarded. Nothing is written to memory or to the descriptor, and the ring position stays where it is. This applies at the start of a frame or in the middle of one. The next start descriptor written on that port then carries bit 4 (overflow), and the flag is cleared.
- R9: If an owned descriptor has bits 7:4 of its high address byte non-zero, it is written back at once. Its status is 0x44 (bits 6 and 2) and its message count is 0, and no bytes go into it. The position advances, and the same frame continues in the next descriptor, which gets the start flag.
- R10: After every write-back, the ring position of that port advances by one modulo RING_DEPTH. Each port keeps its own position.
- R11: evt_valid is high for exactly the write-back cycle when bit 15 of the buffer count is set. In that cycle evt_port and evt_slot name the descriptor.
- R12: rx_ready is high only while frame bytes are being taken. A byte is consumed when rx_valid and rx_ready are both high, and rx_port must be held from the first byte to the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Frame byte present |
| rx_ready | output | 1 | Byte taken this cycle when valid |
| rx_port | input | PORT_W | Port the frame belongs to |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_fram_err | input | 1 | Framing error, valid with the last byte |
| rx_crc_err | input | 1 | CRC error, valid with the last byte |
| desc_rd_en | output | 1 | Descriptor read request |
| desc_rd_addr | output | DADDR_W | Descriptor index (port, position) |
| desc_rd_data | input | DESC_W | Descriptor contents, one cycle after the request |
| desc_wr_en | output | 1 | Descriptor write-back strobe |
| desc_wr_addr | output | DADDR_W | Descriptor index being written back |
| desc_wr_status | output | 8 | New status byte |
| desc_wr_mcnt | output | CNT_W | New message count |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | ADDR_W | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte |
| evt_valid | output | 1 | Completion event |
| evt_port | output | PORT_W | Port of the completed descriptor |
| evt_slot | output | IDX_W | Ring position of the completed descriptor |

## Verification
The hardest cases to reach from the ports are a descriptor that the host still holds partway through a frame, and an owned descriptor whose high address byte is invalid. In both, the frame has to carry on into, or be dropped before, a descriptor other than the first one. The bench keeps its own descriptor memory and changes ownership and address bits in it between frames. It uses a 4-byte buffer size so that short frames cross descriptor boundaries. A sweep of frame lengths 1 to 12 over that small buffer runs the ring round several times, and the expected flags, counts and byte addresses are worked out arithmetically.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_LOOK,
      ST_DATA,
      ST_WB,
      ST_DROP
   } rxd_state_e;

   // status byte bit positions (decoded by the host)
   localparam int unsigned SB_OWN  = 7;
   localparam int unsigned SB_ERR  = 6;
   localparam int unsigned SB_FRAM = 5;
   localparam int unsigned SB_OFLO = 4;
   localparam int unsigned SB_CRC  = 3;
   localparam int unsigned SB_HBUF = 2;
   localparam int unsigned SB_STP  = 1;
   localparam int unsigned SB_ENP  = 0;

endpackage

// File: rtl/rxd_desc_decode.sv
module rxd_desc_decode #(
   parameter int LADR_W    = 16,
   parameter int HADR_USED = 4,
   parameter int CNT_W     = 15,
   localparam int HADR_W   = 8,
   localparam int ADDR_W   = LADR_W + HADR_USED,
   localparam int DESC_W   = LADR_W + HADR_W + 8 + 2 * (CNT_W + 1)
) (
   input  logic [DESC_W-1:0] desc,
   output logic              own,
   output logic              bad_hi,
   output logic [ADDR_W-1:0] base,
   output logic [CNT_W:0]    size,
   output logic              irq_en
);
   import rxd_pkg::*;

   localparam int HADR_LO = LADR_W;
   localparam int STAT_LO = LADR_W + HADR_W;
   localparam int BCNT_LO = STAT_LO + 8;
   localparam int MCNT_LO = BCNT_LO + CNT_W + 1;

   logic [LADR_W-1:0] f_ladr;
   logic [HADR_W-1:0] f_hadr;
   logic [7:0]        f_stat;
   logic [CNT_W:0]    f_bcnt;
   logic              unused_fields;

   assign f_ladr = desc[LADR_W-1:0];
   assign f_hadr = desc[HADR_LO +: HADR_W];
   assign f_stat = desc[STAT_LO +: 8];
   assign f_bcnt = desc[BCNT_LO +: CNT_W + 1];

   assign own    = f_stat[SB_OWN];
   assign bad_hi = |f_hadr[HADR_W-1:HADR_USED];
   assign base   = {f_hadr[HADR_USED-1:0], f_ladr};
   // two's complement size; zero encodes the full 2^CNT_W
   assign size   = {1'b1, {CNT_W{1'b0}}} - {1'b0, f_bcnt[CNT_W-1:0]};
   assign irq_en = f_bcnt[CNT_W];

   assign unused_fields = ^{f_stat[SB_OWN-1:0], desc[DESC_W-1:MCNT_LO]};

endmodule

// File: rtl/rxd_ring_state.sv
module rxd_ring_state #(
   parameter int NUM_PORTS  = 4,
   parameter int RING_DEPTH = 8,
   localparam int PORT_W    = $clog2(NUM_PORTS),
   localparam int IDX_W     = $clog2(RING_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] sel_port,
   input  logic              adv,
   input  logic              set_oflo,
   input  logic              clr_oflo,
   output logic [IDX_W-1:0]  cur_idx,
   output logic              cur_pend
);

   logic [IDX_W-1:0] idx_all  [NUM_PORTS];
   logic             pend_all [NUM_PORTS];

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [IDX_W-1:0] idx_r;
      logic             pend_r;
      logic             hit;

      assign hit = (sel_port == PORT_W'(p));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            idx_r  <= '0;
            pend_r <= 1'b0;
         end else if (hit) begin
            if (adv)           idx_r  <= idx_r + 1'b1;
            if (set_oflo)      pend_r <= 1'b1;
            else if (clr_oflo) pend_r <= 1'b0;
         end
      end

      assign idx_all[p]  = idx_r;
      assign pend_all[p] = pend_r;
   end

   assign cur_idx  = idx_all[sel_port];
   assign cur_pend = pend_all[sel_port];

endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer #(
   parameter int NUM_PORTS  = 4,
   parameter int RING_DEPTH = 8,
   parameter int LADR_W     = 16,
   parameter int HADR_USED  = 4,
   parameter int CNT_W      = 15,
   localparam int PORT_W    = $clog2(NUM_PORTS),
   localparam int IDX_W     = $clog2(RING_DEPTH),
   localparam int DADDR_W   = PORT_W + IDX_W,
   localparam int ADDR_W    = LADR_W + HADR_USED,
   localparam int DESC_W    = LADR_W + 16 + 2 * (CNT_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_valid,
   output logic               rx_ready,
   input  logic [PORT_W-1:0]  rx_port,
   input  logic [7:0]         rx_data,
   input  logic               rx_last,
   input  logic               rx_fram_err,
   input  logic               rx_crc_err,
   output logic               desc_rd_en,
   output logic [DADDR_W-1:0] desc_rd_addr,
   input  logic [DESC_W-1:0]  desc_rd_data,
   output logic               desc_wr_en,
   output logic [DADDR_W-1:0] desc_wr_addr,
   output logic [7:0]         desc_wr_status,
   output logic [CNT_W-1:0]   desc_wr_mcnt,
   output logic               buf_we,
   output logic [ADDR_W-1:0]  buf_addr,
   output logic [7:0]         buf_wdata,
   output logic               evt_valid,
   output logic [PORT_W-1:0]  evt_port,
   output logic [IDX_W-1:0]   evt_slot
);
   import rxd_pkg::*;

   // elaboration-time parameter checks
   if (RING_DEPTH < 2 || (RING_DEPTH & (RING_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("RING_DEPTH must be a power of two, at least 2");
   end
   if (NUM_PORTS < 2 || (NUM_PORTS & (NUM_PORTS - 1)) != 0) begin : g_bad_ports
      $error("NUM_PORTS must be a power of two, at least 2");
   end
   if (HADR_USED < 1 || HADR_USED > 8) begin : g_bad_hadr
      $error("HADR_USED must lie in 1..8");
   end
   if (CNT_W < 2 || CNT_W > 15) begin : g_bad_cnt
      $error("CNT_W must lie in 2..15");
   end

   rxd_state_e        state_q;
   logic [PORT_W-1:0] port_q;
   logic [ADDR_W-1:0] base_q;
   logic [CNT_W:0]    size_q;
   logic [CNT_W:0]    bcnt_q;
   logic [CNT_W-1:0]  flen_q;
   logic              first_q, irq_q, last_q, fram_q, crc_q, hbuf_q;

   logic              d_own, d_bad, d_irq;
   logic [ADDR_W-1:0] d_base;
   logic [CNT_W:0]    d_size;
   logic [IDX_W-1:0]  cur_idx;
   logic              cur_pend;
   logic              wb, stp_w, oflo_w, set_oflo, clr_oflo;
   logic [CNT_W:0]    bcnt_next;

   rxd_desc_decode #(
      .LADR_W   (LADR_W),
      .HADR_USED(HADR_USED),
      .CNT_W    (CNT_W)
   ) u_decode (
      .desc  (desc_rd_data),
      .own   (d_own),
      .bad_hi(d_bad),
      .base  (d_base),
      .size  (d_size),
      .irq_en(d_irq)
   );

   rxd_ring_state #(
      .NUM_PORTS (NUM_PORTS),
      .RING_DEPTH(RING_DEPTH)
   ) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_port(port_q),
      .adv     (wb),
      .set_oflo(set_oflo),
      .clr_oflo(clr_oflo),
      .cur_idx (cur_idx),
      .cur_pend(cur_pend)
   );

   assign wb        = (state_q == ST_WB);
   assign stp_w     = first_q & ~hbuf_q;
   assign oflo_w    = stp_w & cur_pend;
   assign set_oflo  = (state_q == ST_LOOK) & ~d_own;
   assign clr_oflo  = wb & stp_w;
   assign bcnt_next = bcnt_q + 1'b1;

   assign rx_ready     = (state_q == ST_DATA) || (state_q == ST_DROP);
   assign desc_rd_en   = (state_q == ST_FETCH);
   assign desc_rd_addr = {port_q, cur_idx};
   assign desc_wr_en   = wb;
   assign desc_wr_addr = {port_q, cur_idx};
   assign desc_wr_mcnt = hbuf_q ? '0 : flen_q;
   assign buf_we       = (state_q == ST_DATA) & rx_valid;
   assign buf_addr     = base_q + ADDR_W'(bcnt_q);
   assign buf_wdata    = rx_data;
   assign evt_valid    = wb & irq_q;
   assign evt_port     = port_q;
   assign evt_slot     = cur_idx;

   always_comb begin
      desc_wr_status          = '0;
      desc_wr_status[SB_FRAM] = last_q & fram_q;
      desc_wr_status[SB_CRC]  = last_q & crc_q;
      desc_wr_status[SB_OFLO] = oflo_w;
      desc_wr_status[SB_HBUF] = hbuf_q;
      desc_wr_status[SB_ERR]  = (last_q & (fram_q | crc_q)) | oflo_w | hbuf_q;
      desc_wr_status[SB_STP]  = stp_w;
      desc_wr_status[SB_ENP]  = last_q & ~hbuf_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         port_q  <= '0;
         base_q  <= '0;
         size_q  <= '0;
         bcnt_q  <= '0;
         flen_q  <= '0;
         first_q <= 1'b0;
         irq_q   <= 1'b0;
         last_q  <= 1'b0;
         fram_q  <= 1'b0;
         crc_q   <= 1'b0;
         hbuf_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (rx_valid) begin
               port_q  <= rx_port;
               first_q <= 1'b1;
               flen_q  <= '0;
               last_q  <= 1'b0;
               fram_q  <= 1'b0;
               crc_q   <= 1'b0;
               state_q <= ST_FETCH;
            end
            ST_FETCH: state_q <= ST_LOOK;
            ST_LOOK: begin
               irq_q <= d_irq;
               if (!d_own) begin
                  state_q <= ST_DROP;
               end else if (d_bad) begin
                  hbuf_q  <= 1'b1;
                  state_q <= ST_WB;
               end else begin
                  base_q  <= d_base;
                  size_q  <= d_size;
                  bcnt_q  <= '0;
                  state_q <= ST_DATA;
               end
            end
            ST_DATA: if (rx_valid) begin
               bcnt_q <= bcnt_next;
               flen_q <= flen_q + 1'b1;
               if (rx_last) begin
                  last_q  <= 1'b1;
                  fram_q  <= rx_fram_err;
                  crc_q   <= rx_crc_err;
                  state_q <= ST_WB;
               end else if (bcnt_next == size_q) begin
                  state_q <= ST_WB;
               end
            end
            ST_WB: begin
               if (stp_w) first_q <= 1'b0;
               hbuf_q <= 1'b0;
               if (hbuf_q)      state_q <= ST_FETCH;
               else if (last_q) state_q <= ST_IDLE;
               else             state_q <= ST_FETCH;
            end
            ST_DROP: if (rx_valid && rx_last) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R4: a byte never lands past the end of the current buffer
   a_r4_within_buffer: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> (bcnt_q < size_q));

   // R8: an unowned descriptor is never followed by a buffer write
   a_r8_no_write_unowned: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOOK && !d_own) |=> !buf_we);

   // R11: events only accompany a write-back
   a_r11_evt_on_wb: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> desc_wr_en);

   // R2: each fetch request lasts one cycle
   a_r2_fetch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      desc_rd_en |=> !desc_rd_en);

   // R12: memory writes happen only on an accepted byte
   a_r12_write_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> (rx_valid && rx_ready));

endmodule

// File: tb/rxd_ring_writer_tb.sv
module rxd_ring_writer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic        rx_ready;
   logic [1:0]  rx_port = '0;
   logic [7:0]  rx_data = '0;
   logic        rx_last = 1'b0;
   logic        rx_fram_err = 1'b0;
   logic        rx_crc_err = 1'b0;
   logic        desc_rd_en;
   logic [4:0]  desc_rd_addr;
   logic [63:0] desc_rd_data = '0;
   logic        desc_wr_en;
   logic [4:0]  desc_wr_addr;
   logic [7:0]  desc_wr_status;
   logic [14:0] desc_wr_mcnt;
   logic        buf_we;
   logic [19:0] buf_addr;
   logic [7:0]  buf_wdata;
   logic        evt_valid;
   logic [1:0]  evt_port;
   logic [2:0]  evt_slot;

   int checks = 0;
   int errors = 0;
   int nwrites = 0;
   int nevt = 0;
   int last_evt_port = -1;
   int last_evt_slot = -1;

   logic [63:0] dmem [0:31];
   logic [7:0]  bmem [0:2047];

   always #4 clk = ~clk;

   rxd_ring_writer u_dut (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_port(rx_port),
      .rx_data(rx_data), .rx_last(rx_last),
      .rx_fram_err(rx_fram_err), .rx_crc_err(rx_crc_err),
      .desc_rd_en(desc_rd_en), .desc_rd_addr(desc_rd_addr), .desc_rd_data(desc_rd_data),
      .desc_wr_en(desc_wr_en), .desc_wr_addr(desc_wr_addr),
      .desc_wr_status(desc_wr_status), .desc_wr_mcnt(desc_wr_mcnt),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
      .evt_valid(evt_valid), .evt_port(evt_port), .evt_slot(evt_slot)
   );

   // memory model: one-cycle descriptor read, write-back of status and count
   always @(posedge clk) begin
      if (desc_rd_en) desc_rd_data <= dmem[desc_rd_addr];
      if (desc_wr_en) begin
         dmem[desc_wr_addr][31:24] <= desc_wr_status;
         dmem[desc_wr_addr][63:48] <= {1'b0, desc_wr_mcnt};
      end
      if (buf_we) begin
         bmem[buf_addr[10:0]] <= buf_wdata;
         nwrites++;
      end
      if (evt_valid) begin
         nevt++;
         last_evt_port = int'(evt_port);
         last_evt_slot = int'(evt_slot);
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic set_desc(input int p, input int s, input bit own, input bit hi,
                           input int size, input bit irq);
      logic [14:0] bc;
      logic [15:0] base;
      bc   = 15'((32768 - size) & 32767);
      base = 16'((p * 8 + s) * 64);
      dmem[p * 8 + s] = {16'h0000, irq, bc, (own ? 8'h80 : 8'h00),
                         (hi ? 8'h10 : 8'h00), base};
   endtask

   task automatic send_frame(input int p, input int len, input bit fram,
                             input bit crc, input logic [7:0] seed);
      rx_port = 2'(p);
      for (int i = 0; i < len; i++) begin
         rx_data     = seed + 8'(i);
         rx_last     = (i == len - 1);
         rx_fram_err = fram && (i == len - 1);
         rx_crc_err  = crc && (i == len - 1);
         rx_valid    = 1'b1;
         #1;
         while (!rx_ready) @(negedge clk);
         @(negedge clk);
      end
      rx_valid = 1'b0;
      rx_last  = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic check_desc(input string req, input int p, input int s,
                             input int st, input int mc);
      chk(req, $sformatf("status p%0d s%0d", p, s), int'(dmem[p * 8 + s][31:24]), st);
      chk(req, $sformatf("mcnt p%0d s%0d", p, s), int'(dmem[p * 8 + s][62:48]), mc);
   endtask

   task automatic check_bytes(input string req, input int p, input int s,
                              input int n, input logic [7:0] seed);
      int bad = 0;
      int base = (p * 8 + s) * 64;
      for (int k = 0; k < n; k++)
         if (bmem[base + k] !== seed + 8'(k)) bad++;
      chk(req, $sformatf("bytes p%0d s%0d mismatches", p, s), bad, 0);
   endtask

   task automatic summary;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      int w0, e0, sl;
      for (int p = 0; p < 4; p++)
         for (int s = 0; s < 8; s++) set_desc(p, s, 1'b1, 1'b0, 16, 1'b1);
      for (int i = 0; i < 2048; i++) bmem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1", "rx_ready", int'(rx_ready), 0);
      chk("R1", "buf_we", int'(buf_we), 0);
      chk("R1", "desc_rd_en", int'(desc_rd_en), 0);
      chk("R1", "desc_wr_en", int'(desc_wr_en), 0);
      chk("R1", "evt_valid", int'(evt_valid), 0);

      // R2 R3 R4 R6 R11: single frame fits, port 0 slot 0 (position 0 after reset)
      e0 = nevt;
      send_frame(0, 5, 1'b0, 1'b0, 8'h10);
      check_desc("R3", 0, 0, 8'h03, 5);
      check_bytes("R4", 0, 0, 5, 8'h10);
      chk("R11", "event count", nevt - e0, 1);
      chk("R11", "event port", last_evt_port, 0);
      chk("R11", "event slot", last_evt_slot, 0);

      // R7 error flags on port 2
      send_frame(2, 3, 1'b0, 1'b1, 8'h20);
      check_desc("R7", 2, 0, 8'h4B, 3);
      send_frame(2, 2, 1'b1, 1'b0, 8'h30);
      check_desc("R7", 2, 1, 8'h63, 2);
      send_frame(2, 4, 1'b1, 1'b1, 8'h40);
      check_desc("R7", 2, 2, 8'h6B, 4);

      // R11 interrupt disabled: no event
      set_desc(2, 3, 1'b1, 1'b0, 16, 1'b0);
      e0 = nevt;
      send_frame(2, 2, 1'b0, 1'b0, 8'h50);
      chk("R11", "event with irq off", nevt - e0, 0);
      check_desc("R11", 2, 3, 8'h03, 2);

      // R8 unowned at frame start, port 0 slot 1
      set_desc(0, 1, 1'b0, 1'b0, 16, 1'b1);
      w0 = nwrites;
      send_frame(0, 3, 1'b0, 1'b0, 8'h60);
      chk("R8", "writes during drop", nwrites - w0, 0);
      check_desc("R8", 0, 1, 8'h00, 0);
      set_desc(0, 1, 1'b1, 1'b0, 16, 1'b1);
      send_frame(0, 2, 1'b0, 1'b0, 8'h70);
      check_desc("R8", 0, 1, 8'h53, 2);
      check_bytes("R8", 0, 1, 2, 8'h70);
      send_frame(0, 1, 1'b0, 1'b0, 8'h78);
      check_desc("R8", 0, 2, 8'h03, 1);

      // R8 R5 unowned in mid-frame, port 0 slot 3 size 4, slot 4 held by host
      set_desc(0, 3, 1'b1, 1'b0, 4, 1'b1);
      set_desc(0, 4, 1'b0, 1'b0, 16, 1'b1);
      w0 = nwrites;
      send_frame(0, 6, 1'b0, 1'b0, 8'h80);
      check_desc("R5", 0, 3, 8'h02, 4);
      chk("R8", "writes before mid-frame drop", nwrites - w0, 4);
      set_desc(0, 4, 1'b1, 1'b0, 16, 1'b1);
      send_frame(0, 2, 1'b0, 1'b0, 8'h90);
      check_desc("R8", 0, 4, 8'h53, 2);

      // R9 bad high address byte, port 1 slot 0
      set_desc(1, 0, 1'b1, 1'b1, 16, 1'b1);
      w0 = nwrites;
      send_frame(1, 3, 1'b0, 1'b0, 8'hA0);
      check_desc("R9", 1, 0, 8'h44, 0);
      check_desc("R9", 1, 1, 8'h03, 3);
      check_bytes("R9", 1, 1, 3, 8'hA0);
      chk("R9", "write count", nwrites - w0, 3);

      // R5 R6 R10 sweep: port 3, buffer 4, frame lengths 1..12
      for (int s = 0; s < 8; s++) set_desc(3, s, 1'b1, 1'b0, 4, 1'b1);
      sl = 0;
      for (int len = 1; len <= 12; len++) begin
         int nd;
         logic [7:0] seed;
         nd   = (len + 3) / 4;
         seed = 8'(len * 16);
         e0   = nevt;
         send_frame(3, len, 1'b0, 1'b0, seed);
         chk("R11", $sformatf("sweep events len %0d", len), nevt - e0, nd);
         for (int d = 0; d < nd; d++) begin
            int slot, here, st;
            slot = (sl + d) % 8;
            here = (len - 4 * d > 4) ? 4 : len - 4 * d;
            st   = ((d == 0) ? 2 : 0) | ((d == nd - 1) ? 1 : 0);
            check_desc("R5", 3, slot, st, 4 * d + here);
            check_bytes("R10", 3, slot, here, seed + 8'(4 * d));
            set_desc(3, slot, 1'b1, 1'b0, 4, 1'b1);
         end
         sl = (sl + nd) % 8;
      end

      // R10 ring wrap on port 1: positions 2..7 then back to 0
      for (int s = 2; s < 8; s++) send_frame(1, 1, 1'b0, 1'b0, 8'(s));
      check_desc("R10", 1, 7, 8'h03, 1);
      set_desc(1, 0, 1'b1, 1'b0, 16, 1'b1);
      send_frame(1, 3, 1'b0, 1'b0, 8'hC0);
      check_desc("R10", 1, 0, 8'h03, 3);
      check_bytes("R10", 1, 0, 3, 8'hC0);
      chk("R12", "rx_ready when idle", int'(rx_ready), 0);

      summary();
   end

endmodule